// File: doc/BRIEF.md
# Bitfield Alias Preference Classifier

This combinational block serves a disassembly or trace unit. It takes the fields of a decoded bitfield-move or logical-immediate instruction. From them it decides whether one of two preferred alias mnemonics applies.

The first output, `extract_pref`, is high when the plain bitfield-extract alias should be printed. It drops whenever a more specific alias takes over: the insert form, a shift form, or a byte, halfword or word extend form.

The second output, `movewide_pref`, is high when the logical immediate that the fields describe could also be made by one move-wide instruction. That instruction is either the zeroing kind or the inverting kind. For this to hold, the ones or the zeros must fit inside a single 16-bit lane after rotation.

The block has no clock and no state. The house layout of state register plus output process has no counterpart here, so the design is split into one rule module per output, and these share a package of field constants.

Top module: `alias_pref_classifier`

## Requirements
- R1: `extract_pref` is 0 whenever `len_field` < `rot_field`, with both read as unsigned 6-bit values (the insert form).
- R2: `extract_pref` is 0 whenever `len_field` equals {`wide_sel`, 5'b11111}, that is 31 for 32-bit and 63 for 64-bit (a shift form).
- R3: With `rot_field` = 0 and `wide_sel` = 0, `extract_pref` is 0 when `len_field` is 7 or 15 (the 32-bit extend forms).
- R4: With `rot_field` = 0, `wide_sel` = 1 and `unsigned_op` = 0 (signed), `extract_pref` is 0 when `len_field` is 7, 15 or 31 (the 64-bit signed extend forms).
- R5: When none of R1 to R4 applies, `extract_pref` is 1.
- R6: `movewide_pref` is 0 unless the element size is the full width. With `wide_sel` = 1 this needs `n_flag` = 1. With `wide_sel` = 0 it needs `n_flag` = 0 and bit 5 of `len_field` = 0.
- R7: When R6 allows and S = `len_field` is below 16, `movewide_pref` equals ((−R) mod 16) ≤ 15 − S, where R = `rot_field`.
- R8: When R6 allows, S ≥ 16, and S ≥ W − 15 (W = 64 when `wide_sel` = 1, else 32), `movewide_pref` equals (R mod 16) ≤ S − (W − 15).
- R9: When R6 allows and S lies in 16 .. W − 16, `movewide_pref` is 0.
- R10: Both outputs are purely combinational. They reflect a new input set within the same time step, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wide_sel | input | 1 | 1 for the 64-bit form, 0 for the 32-bit form |
| unsigned_op | input | 1 | 1 for the unsigned bitfield op, 0 for signed |
| n_flag | input | 1 | N bit of the immediate encoding |
| len_field | input | 6 | imms field (S) |
| rot_field | input | 6 | immr field (R) |
| extract_pref | output | 1 | bitfield-extract alias is preferred |
| movewide_pref | output | 1 | immediate fits a single move-wide instruction |

## Verification
The hardest cases to reach sit on the edge of the halfword-fit tests. There the rotation lands the run of ones or zeros exactly against a 16-bit boundary, and a rotation one step further crosses it. The same holds at the extend-form exclusions, which only fire with a rotation of zero and one exact length. Directed tasks first pin these cases in pairs, one that fits and one off by one. An exhaustive sweep over every combination of the five inputs then compares both outputs with an integer model.

// File: rtl/alias_pref_pkg.sv
package alias_pref_pkg;
    localparam int FIELD_W  = 6;
    localparam int LANE_W   = 16;
    localparam int LANE_BW  = $clog2(LANE_W);
    localparam int WIDE_W   = 1 << FIELD_W;
    localparam int NARROW_W = 1 << (FIELD_W - 1);
    localparam int CALC_W   = FIELD_W + 1;
    localparam int INV_SPAN = LANE_W - 1;

    typedef logic [FIELD_W-1:0]        field_t;
    typedef logic signed [CALC_W-1:0]  calc_t;
endpackage

// File: rtl/extract_rule.sv
module extract_rule
    import alias_pref_pkg::*;
(
    input  logic   wide_sel,
    input  logic   unsigned_op,
    input  field_t len_field,
    input  field_t rot_field,
    output logic   insert_form,
    output logic   extract_pref
);
    logic [CALC_W-1:0] gap;
    logic              shift_form;
    logic              rot_zero;
    logic              ext_narrow;
    logic              ext_wide_signed;

    always_comb begin
        gap        = {1'b0, len_field} - {1'b0, rot_field};
        // borrow out of the subtract marks the insert form
        insert_form = gap[CALC_W-1];
        shift_form = (len_field == {wide_sel, {(FIELD_W-1){1'b1}}});
        rot_zero   = (rot_field == '0);
        ext_narrow = rot_zero && !wide_sel &&
                     (len_field == field_t'(7) || len_field == field_t'(15));
        ext_wide_signed = rot_zero && wide_sel && !unsigned_op &&
                     (len_field == field_t'(7) || len_field == field_t'(15) ||
                      len_field == field_t'(31));
        extract_pref = !(insert_form || shift_form || ext_narrow || ext_wide_signed);
    end
endmodule

// File: rtl/movewide_rule.sv
module movewide_rule
    import alias_pref_pkg::*;
(
    input  logic   wide_sel,
    input  logic   n_flag,
    input  field_t len_field,
    input  field_t rot_field,
    output logic   size_ok,
    output logic   movewide_pref
);
    logic [LANE_BW-1:0] neg_rot;
    calc_t              s_val;
    calc_t              ones_room;
    calc_t              inv_base;
    calc_t              zeros_room;
    logic               ones_fit;
    logic               zeros_fit;

    always_comb begin
        size_ok = wide_sel ? n_flag : (!n_flag && !len_field[FIELD_W-1]);
        s_val   = calc_t'({1'b0, len_field});
        neg_rot = LANE_BW'(0) - rot_field[LANE_BW-1:0];
        ones_room  = calc_t'(LANE_W - 1) - s_val;
        inv_base   = wide_sel ? calc_t'(WIDE_W - INV_SPAN) : calc_t'(NARROW_W - INV_SPAN);
        zeros_room = s_val - inv_base;
        ones_fit   = calc_t'({3'b000, neg_rot}) <= ones_room;
        zeros_fit  = calc_t'({3'b000, rot_field[LANE_BW-1:0]}) <= zeros_room;
        if (!size_ok) begin
            movewide_pref = 1'b0;
        end else if (s_val < calc_t'(LANE_W)) begin
            movewide_pref = ones_fit;
        end else if (s_val >= inv_base) begin
            movewide_pref = zeros_fit;
        end else begin
            movewide_pref = 1'b0;
        end
    end
endmodule

// File: rtl/alias_pref_classifier.sv
module alias_pref_classifier
    import alias_pref_pkg::*;
(
    input  logic                wide_sel,
    input  logic                unsigned_op,
    input  logic                n_flag,
    input  logic [FIELD_W-1:0]  len_field,
    input  logic [FIELD_W-1:0]  rot_field,
    output logic                extract_pref,
    output logic                movewide_pref
);
    logic insert_form;
    logic size_ok;

    extract_rule u_extract (
        .wide_sel     (wide_sel),
        .unsigned_op  (unsigned_op),
        .len_field    (len_field),
        .rot_field    (rot_field),
        .insert_form  (insert_form),
        .extract_pref (extract_pref)
    );

    movewide_rule u_movewide (
        .wide_sel      (wide_sel),
        .n_flag        (n_flag),
        .len_field     (len_field),
        .rot_field     (rot_field),
        .size_ok       (size_ok),
        .movewide_pref (movewide_pref)
    );

    always_comb begin
        // R1
        insert_excl_chk: assert (!(len_field < rot_field) || !extract_pref);
        // R1
        insert_flag_chk: assert ((len_field < rot_field) == insert_form);
        // R2
        shift_excl_chk: assert (len_field != {wide_sel, 5'b11111} || !extract_pref);
        // R3
        ext32_excl_chk: assert (!(rot_field == '0 && !wide_sel &&
                                 (len_field == 6'd7 || len_field == 6'd15)) || !extract_pref);
        // R6
        size_gate_chk: assert (size_ok || !movewide_pref);
        // R9
        mid_range_chk: assert (!(len_field >= 6'd16 &&
                                 int'(len_field) <= (wide_sel ? 48 : 16)) || !movewide_pref);
    end
endmodule

// File: tb/alias_pref_classifier_tb.sv
`timescale 1ns/1ps
module alias_pref_classifier_tb;
    logic       clk = 1'b0;
    logic       wide_sel, unsigned_op, n_flag;
    logic [5:0] len_field, rot_field;
    logic       extract_pref, movewide_pref;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    alias_pref_classifier u_dut (
        .wide_sel      (wide_sel),
        .unsigned_op   (unsigned_op),
        .n_flag        (n_flag),
        .len_field     (len_field),
        .rot_field     (rot_field),
        .extract_pref  (extract_pref),
        .movewide_pref (movewide_pref)
    );

    function automatic bit ref_bfx(int sf, int uns, int s, int r);
        if (s < r) return 0;
        if (s == sf * 32 + 31) return 0;
        if (r == 0) begin
            if (sf == 0 && (s == 7 || s == 15)) return 0;
            if (sf == 1 && uns == 0 && (s == 7 || s == 15 || s == 31)) return 0;
        end
        return 1;
    endfunction

    function automatic bit ref_mov(int sf, int n, int s, int r);
        int w = (sf != 0) ? 64 : 32;
        if (sf != 0 && n == 0) return 0;
        if (sf == 0 && (n != 0 || s >= 32)) return 0;
        if (s < 16) return ((16 - (r % 16)) % 16) <= (15 - s);
        if (s >= w - 15) return (r % 16) <= (s - (w - 15));
        return 0;
    endfunction

    task automatic apply(input int sf, input int uns, input int n, input int s, input int r);
        @(posedge clk);
        wide_sel = sf[0]; unsigned_op = uns[0]; n_flag = n[0];
        len_field = s[5:0]; rot_field = r[5:0];
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s sf=%0d u=%0d n=%0d s=%0d r=%0d got=%0b exp=%0b",
                     req, wide_sel, unsigned_op, n_flag, len_field, rot_field, got, exp);
        end
    endtask

    task automatic t_idle();
        apply(0, 0, 0, 0, 0);
        chk("R5", extract_pref, 1'b1);
        chk("R7", movewide_pref, 1'b1);
    endtask

    task automatic t_insert();
        apply(1, 1, 1, 4, 5);  chk("R1", extract_pref, 1'b0);
        apply(1, 1, 1, 5, 5);  chk("R5", extract_pref, 1'b1);
        apply(0, 0, 0, 0, 63); chk("R1", extract_pref, 1'b0);
    endtask

    task automatic t_shift();
        apply(0, 1, 0, 31, 3); chk("R2", extract_pref, 1'b0);
        apply(1, 0, 1, 63, 9); chk("R2", extract_pref, 1'b0);
        apply(1, 0, 1, 31, 3); chk("R5", extract_pref, 1'b1);
    endtask

    task automatic t_ext();
        apply(0, 1, 0, 7, 0);  chk("R3", extract_pref, 1'b0);
        apply(0, 0, 0, 15, 0); chk("R3", extract_pref, 1'b0);
        apply(0, 0, 0, 15, 1); chk("R5", extract_pref, 1'b1);
        apply(1, 0, 1, 31, 0); chk("R4", extract_pref, 1'b0);
        apply(1, 0, 1, 7, 0);  chk("R4", extract_pref, 1'b0);
        apply(1, 1, 1, 15, 0); chk("R5", extract_pref, 1'b1);
    endtask

    task automatic t_size();
        apply(1, 0, 0, 0, 0);  chk("R6", movewide_pref, 1'b0);
        apply(0, 0, 1, 0, 0);  chk("R6", movewide_pref, 1'b0);
        apply(0, 0, 0, 32, 0); chk("R6", movewide_pref, 1'b0);
    endtask

    task automatic t_ones();
        apply(1, 0, 1, 15, 0); chk("R7", movewide_pref, 1'b1);
        apply(1, 0, 1, 15, 1); chk("R7", movewide_pref, 1'b0);
        apply(1, 0, 1, 3, 4);  chk("R7", movewide_pref, 1'b1);
        apply(1, 0, 1, 3, 3);  chk("R7", movewide_pref, 1'b0);
    endtask

    task automatic t_zeros();
        apply(0, 0, 0, 17, 0); chk("R8", movewide_pref, 1'b1);
        apply(0, 0, 0, 17, 1); chk("R8", movewide_pref, 1'b0);
        apply(1, 0, 1, 63, 14); chk("R8", movewide_pref, 1'b1);
        apply(1, 0, 1, 63, 15); chk("R8", movewide_pref, 1'b0);
        apply(1, 0, 1, 48, 0); chk("R9", movewide_pref, 1'b0);
        apply(0, 0, 0, 16, 0); chk("R9", movewide_pref, 1'b0);
    endtask

    task automatic t_comb();
        // R10: settles in the same time step, no edge needed
        @(negedge clk);
        wide_sel = 1'b1; unsigned_op = 1'b0; n_flag = 1'b1;
        len_field = 6'd4; rot_field = 6'd9;
        #1;
        chk("R10", extract_pref, 1'b0);
        len_field = 6'd9;
        #1;
        chk("R10", extract_pref, 1'b1);
    endtask

    task automatic t_sweep();
        for (int sf = 0; sf < 2; sf++)
            for (int u = 0; u < 2; u++)
                for (int n = 0; n < 2; n++)
                    for (int s = 0; s < 64; s++)
                        for (int r = 0; r < 64; r++) begin
                            apply(sf, u, n, s, r);
                            chk("R1..R5 sweep", extract_pref, ref_bfx(sf, u, s, r));
                            chk("R6..R9 sweep", movewide_pref, ref_mov(sf, n, s, r));
                        end
    endtask

    initial begin
        wide_sel = 0; unsigned_op = 0; n_flag = 0; len_field = 0; rot_field = 0;
        t_idle();
        t_insert();
        t_shift();
        t_ext();
        t_size();
        t_ones();
        t_zeros();
        t_comb();
        t_sweep();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule